// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block picks the sources of the operands in a five-stage in-order pipeline that runs a simple load/store instruction set. It is purely combinational. It compares the two source register numbers of the instruction in the execute stage with the destination register numbers of the two older instructions. The older instructions sit in the memory stage and the write-back stage. From that comparison it drives a 2-bit select for each ALU operand mux. The first ALU operand follows the first source register (`rs`) and the second follows the second source register (`rt`). Each operand can take the register-file value latched for the execute stage, the result held in the memory stage, or the result held in the write-back stage.

It also drives a 1-bit select for the store-data path in the memory stage. A load in write-back may be followed directly by a store in the memory stage, with the store's data register equal to the load's destination. In that case the loaded word is steered into the store data instead of the stale register value. The datapath muxes, the register file and stall insertion sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: Each ALU operand select is coded 2'b00 for the execute-stage register value, 2'b01 for the memory-stage result and 2'b10 for the write-back result. The code 2'b11 never appears.
- R2: The memory stage is a forwarding source only when it is valid, its register-write flag is 1 and its memory-read flag is 0. With memory-read at 1, no operand select is 2'b01.
- R3: The write-back stage is a forwarding source only when it is valid, its register-write flag is 1 and its memory-read flag is 0. With memory-read at 1, no operand select is 2'b10.
- R4: The first operand select compares only `idex_rs` and the second compares only `idex_rt`. The two are decided independently, so one operand may forward while the other does not.
- R5: When both older stages qualify and match the same source register, the select is 2'b01 (memory stage). 2'b10 is given only when the memory stage does not match.
- R6: A destination register number of 0 never causes any forward, neither for an operand nor for store data.
- R7: An older stage whose valid bit is 0 never causes any forward, whatever its other control bits hold.
- R8: When the execute-stage valid bit is 0, both operand selects are 2'b00.
- R9: `fwd_store_sel` is 1 when all of the following hold: the write-back stage is a valid load (register-write 1 and memory-read 1); the memory stage is a valid store (memory-write 1); the store's data register `exmem_rt` equals the nonzero load destination `memwb_rd`.
- R10: In every other case `fwd_store_sel` is 0. This includes a matching write-back instruction that is not a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_valid | input | 1 | Execute stage holds a real instruction |
| idex_rs | input | REG_ADDR_W | First source register in execute stage |
| idex_rt | input | REG_ADDR_W | Second source register in execute stage |
| exmem_valid | input | 1 | Memory stage holds a real instruction |
| exmem_rd | input | REG_ADDR_W | Destination register in memory stage |
| exmem_rt | input | REG_ADDR_W | Store-data register in memory stage |
| exmem_reg_write | input | 1 | Memory-stage instruction writes a register |
| exmem_mem_read | input | 1 | Memory-stage instruction is a load |
| exmem_mem_write | input | 1 | Memory-stage instruction is a store |
| memwb_valid | input | 1 | Write-back stage holds a real instruction |
| memwb_rd | input | REG_ADDR_W | Destination register in write-back stage |
| memwb_reg_write | input | 1 | Write-back instruction writes a register |
| memwb_mem_read | input | 1 | Write-back instruction is a load |
| fwd_a_sel | output | 2 | Source select for the first ALU operand |
| fwd_b_sel | output | 2 | Source select for the second ALU operand |
| fwd_store_sel | output | 1 | Steer write-back load data into store data |

## Verification
The bench builds the block with `REG_ADDR_W` = 2, so there are four registers, one of which is the hardwired zero register. At that width, every combination of the two source numbers, both destination numbers and all valid, write and read flags fits in one sweep of 32768 vectors. That sweep covers every priority collision, every zero-register case and every bubble case. A second sweep of 512 vectors enumerates every load/store pairing for the store-data select. A short directed prologue pins down the reset-time value and a few named cases.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_IDEX  = 2'b00,
    SRC_EXMEM = 2'b01,
    SRC_MEMWB = 2'b10
  } fwd_src_e;

  // A stage can supply an ALU result if it is live, writes a register,
  // is not a load and targets a real (nonzero) register.
  function automatic logic alu_src_ok(input logic valid,
                                      input logic reg_write,
                                      input logic mem_read,
                                      input logic dest_nonzero);
    return valid & reg_write & ~mem_read & dest_nonzero;
  endfunction

  // A stage holds load data worth forwarding into a following store.
  function automatic logic load_src_ok(input logic valid,
                                       input logic reg_write,
                                       input logic mem_read,
                                       input logic dest_nonzero);
    return valid & reg_write & mem_read & dest_nonzero;
  endfunction

  // Younger stage first; older stage only when the younger misses.
  function automatic fwd_src_e pick_src(input logic consumer_valid,
                                        input logic hit_young,
                                        input logic hit_old);
    fwd_src_e s;
    if (!consumer_valid)  s = SRC_IDEX;
    else if (hit_young)   s = SRC_EXMEM;
    else if (hit_old)     s = SRC_MEMWB;
    else                  s = SRC_IDEX;
    return s;
  endfunction

endpackage

// File: rtl/fwd_stage_qual.sv
module fwd_stage_qual #(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  valid,
  input  logic [REG_ADDR_W-1:0] dest,
  input  logic                  reg_write,
  input  logic                  mem_read,
  output logic                  alu_ok,
  output logic                  load_ok
);
  import fwd_pkg::*;

  logic dest_nonzero;

  assign dest_nonzero = |dest;
  assign alu_ok  = alu_src_ok(valid, reg_write, mem_read, dest_nonzero);
  assign load_ok = load_src_ok(valid, reg_write, mem_read, dest_nonzero);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  consumer_valid,
  input  logic [REG_ADDR_W-1:0] src_reg,
  input  logic                  young_ok,
  input  logic [REG_ADDR_W-1:0] young_dest,
  input  logic                  old_ok,
  input  logic [REG_ADDR_W-1:0] old_dest,
  output logic                  hit_young,
  output logic                  hit_old,
  output logic [1:0]            sel
);
  import fwd_pkg::*;

  fwd_src_e src;

  assign hit_young = young_ok & (young_dest == src_reg);
  assign hit_old   = old_ok   & (old_dest   == src_reg);

  always_comb begin
    src = pick_src(consumer_valid, hit_young, hit_old);
    sel = src;
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  store_valid,
  input  logic                  store_mem_write,
  input  logic [REG_ADDR_W-1:0] store_data_reg,
  input  logic                  load_ok,
  input  logic [REG_ADDR_W-1:0] load_dest,
  output logic                  sel
);
  logic is_store;

  assign is_store = store_valid & store_mem_write;
  assign sel      = is_store & load_ok & (store_data_reg == load_dest);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  idex_valid,
  input  logic [REG_ADDR_W-1:0] idex_rs,
  input  logic [REG_ADDR_W-1:0] idex_rt,
  input  logic                  exmem_valid,
  input  logic [REG_ADDR_W-1:0] exmem_rd,
  input  logic [REG_ADDR_W-1:0] exmem_rt,
  input  logic                  exmem_reg_write,
  input  logic                  exmem_mem_read,
  input  logic                  exmem_mem_write,
  input  logic                  memwb_valid,
  input  logic [REG_ADDR_W-1:0] memwb_rd,
  input  logic                  memwb_reg_write,
  input  logic                  memwb_mem_read,
  output logic [1:0]            fwd_a_sel,
  output logic [1:0]            fwd_b_sel,
  output logic                  fwd_store_sel
);
  localparam int NUM_STAGES   = 2;  // 0: memory stage, 1: write-back stage
  localparam int NUM_OPERANDS = 2;  // 0: first operand (rs), 1: second (rt)

  // Per-stage inputs gathered into arrays so one generate loop serves both.
  logic                  stg_valid [NUM_STAGES];
  logic [REG_ADDR_W-1:0] stg_dest  [NUM_STAGES];
  logic                  stg_rw    [NUM_STAGES];
  logic                  stg_mr    [NUM_STAGES];

  // Named internal events, visible to the bound checker.
  logic [NUM_STAGES-1:0]   alu_ok;
  logic [NUM_STAGES-1:0]   load_ok;
  logic [NUM_OPERANDS-1:0] hit_ex;
  logic [NUM_OPERANDS-1:0] hit_wb;
  logic [1:0]              op_sel [NUM_OPERANDS];
  logic [REG_ADDR_W-1:0]   op_src [NUM_OPERANDS];

  assign stg_valid[0] = exmem_valid;
  assign stg_dest[0]  = exmem_rd;
  assign stg_rw[0]    = exmem_reg_write;
  assign stg_mr[0]    = exmem_mem_read;
  assign stg_valid[1] = memwb_valid;
  assign stg_dest[1]  = memwb_rd;
  assign stg_rw[1]    = memwb_reg_write;
  assign stg_mr[1]    = memwb_mem_read;

  assign op_src[0] = idex_rs;
  assign op_src[1] = idex_rt;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    fwd_stage_qual #(.REG_ADDR_W(REG_ADDR_W)) u_qual (
      .valid     (stg_valid[s]),
      .dest      (stg_dest[s]),
      .reg_write (stg_rw[s]),
      .mem_read  (stg_mr[s]),
      .alu_ok    (alu_ok[s]),
      .load_ok   (load_ok[s])
    );
  end

  for (genvar o = 0; o < NUM_OPERANDS; o++) begin : g_operand
    fwd_operand_sel #(.REG_ADDR_W(REG_ADDR_W)) u_sel (
      .consumer_valid (idex_valid),
      .src_reg        (op_src[o]),
      .young_ok       (alu_ok[0]),
      .young_dest     (exmem_rd),
      .old_ok         (alu_ok[1]),
      .old_dest       (memwb_rd),
      .hit_young      (hit_ex[o]),
      .hit_old        (hit_wb[o]),
      .sel            (op_sel[o])
    );
  end

  fwd_store_sel #(.REG_ADDR_W(REG_ADDR_W)) u_store (
    .store_valid     (exmem_valid),
    .store_mem_write (exmem_mem_write),
    .store_data_reg  (exmem_rt),
    .load_ok         (load_ok[1]),
    .load_dest       (memwb_rd),
    .sel             (fwd_store_sel)
  );

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_ADDR_W = 5
) (
  input logic                  idex_valid,
  input logic                  exmem_valid,
  input logic [REG_ADDR_W-1:0] exmem_rd,
  input logic                  exmem_mem_read,
  input logic                  exmem_mem_write,
  input logic                  memwb_valid,
  input logic [REG_ADDR_W-1:0] memwb_rd,
  input logic                  memwb_mem_read,
  input logic [1:0]            alu_ok,
  input logic [1:0]            load_ok,
  input logic [1:0]            hit_ex,
  input logic [1:0]            hit_wb,
  input logic [1:0]            fwd_a_sel,
  input logic [1:0]            fwd_b_sel,
  input logic                  fwd_store_sel
);
  always_comb begin
    assert_sel_code_R1: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
      else $error("select code 11 produced");
    assert_ex_load_no_fwd_R2: assert (!(exmem_mem_read || load_ok[0]) ||
                                      (fwd_a_sel != 2'b01 && fwd_b_sel != 2'b01))
      else $error("load in memory stage forwarded to ALU");
    assert_wb_load_no_fwd_R3: assert (!memwb_mem_read ||
                                      (fwd_a_sel != 2'b10 && fwd_b_sel != 2'b10))
      else $error("load in write-back stage forwarded to ALU");
    assert_young_wins_R5: assert (!(idex_valid && hit_ex[0] && hit_wb[0]) ||
                                  fwd_a_sel == 2'b01)
      else $error("priority lost on first operand");
    assert_young_wins_b_R5: assert (!(idex_valid && hit_ex[1] && hit_wb[1]) ||
                                    fwd_b_sel == 2'b01)
      else $error("priority lost on second operand");
    assert_zero_dest_R6: assert ((exmem_rd != '0 ||
                                  (fwd_a_sel != 2'b01 && fwd_b_sel != 2'b01)) &&
                                 (memwb_rd != '0 ||
                                  (fwd_a_sel != 2'b10 && fwd_b_sel != 2'b10 && !fwd_store_sel)))
      else $error("register zero forwarded");
    assert_bubble_src_R7: assert ((exmem_valid || (!alu_ok[0] &&
                                   fwd_a_sel != 2'b01 && fwd_b_sel != 2'b01)) &&
                                  (memwb_valid || (!alu_ok[1] && !fwd_store_sel &&
                                   fwd_a_sel != 2'b10 && fwd_b_sel != 2'b10)))
      else $error("bubble stage forwarded");
    assert_bubble_consumer_R8: assert (idex_valid ||
                                       (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00))
      else $error("forward into an empty execute stage");
    assert_store_needs_pair_R10: assert (!fwd_store_sel ||
                                         (load_ok[1] && exmem_mem_write && exmem_valid))
      else $error("store forward without load/store pair");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
  .idex_valid      (idex_valid),
  .exmem_valid     (exmem_valid),
  .exmem_rd        (exmem_rd),
  .exmem_mem_read  (exmem_mem_read),
  .exmem_mem_write (exmem_mem_write),
  .memwb_valid     (memwb_valid),
  .memwb_rd        (memwb_rd),
  .memwb_mem_read  (memwb_mem_read),
  .alu_ok          (alu_ok),
  .load_ok         (load_ok),
  .hit_ex          (hit_ex),
  .hit_wb          (hit_wb),
  .fwd_a_sel       (fwd_a_sel),
  .fwd_b_sel       (fwd_b_sel),
  .fwd_store_sel   (fwd_store_sel)
);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 2;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         idex_valid, exmem_valid, memwb_valid;
  logic [W-1:0] idex_rs, idex_rt, exmem_rd, exmem_rt, memwb_rd;
  logic         exmem_reg_write, exmem_mem_read, exmem_mem_write;
  logic         memwb_reg_write, memwb_mem_read;
  logic [1:0]   fwd_a_sel, fwd_b_sel;
  logic         fwd_store_sel;

  fwd_unit #(.REG_ADDR_W(W)) dut (
    .idex_valid(idex_valid), .idex_rs(idex_rs), .idex_rt(idex_rt),
    .exmem_valid(exmem_valid), .exmem_rd(exmem_rd), .exmem_rt(exmem_rt),
    .exmem_reg_write(exmem_reg_write), .exmem_mem_read(exmem_mem_read),
    .exmem_mem_write(exmem_mem_write),
    .memwb_valid(memwb_valid), .memwb_rd(memwb_rd),
    .memwb_reg_write(memwb_reg_write), .memwb_mem_read(memwb_mem_read),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .fwd_store_sel(fwd_store_sel)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      report();
    end
  end

  // Expected operand select, restated from R1..R8.
  function automatic int exp_op(int src, int idv, int exv, int exrd, int exrw, int exmr,
                                int wbv, int wbrd, int wbrw, int wbmr);
    bit ex_q, wb_q;
    if (idv == 0) return 0;
    ex_q = (exv == 1) && (exrw == 1) && (exmr == 0) && (exrd != 0) && (exrd == src);
    wb_q = (wbv == 1) && (wbrw == 1) && (wbmr == 0) && (wbrd != 0) && (wbrd == src);
    if (ex_q) return 1;
    if (wb_q) return 2;
    return 0;
  endfunction

  // Expected store-data select, restated from R9/R10.
  function automatic int exp_st(int exv, int exmw, int exrt, int wbv, int wbrd, int wbrw, int wbmr);
    return ((exv == 1) && (exmw == 1) && (wbv == 1) && (wbrw == 1) && (wbmr == 1) &&
            (wbrd != 0) && (wbrd == exrt)) ? 1 : 0;
  endfunction

  function automatic string op_tag(int idv, int exv, int exrd, int exmr, int wbv, int wbrd, int wbmr, int exp);
    if (idv == 0)               return "R8";
    if (exrd == 0 || wbrd == 0) return "R6";
    if (exv == 0 || wbv == 0)   return "R7";
    if (exmr == 1)              return "R2";
    if (wbmr == 1)              return "R3";
    if (exp == 1)               return "R5";
    return "R4";
  endfunction

  task automatic drive(int idv, int rs, int rt, int exv, int exrd, int exrt, int exrw, int exmr,
                       int exmw, int wbv, int wbrd, int wbrw, int wbmr);
    @(posedge clk);
    idex_valid = 1'(idv); idex_rs = W'(rs); idex_rt = W'(rt);
    exmem_valid = 1'(exv); exmem_rd = W'(exrd); exmem_rt = W'(exrt);
    exmem_reg_write = 1'(exrw); exmem_mem_read = 1'(exmr); exmem_mem_write = 1'(exmw);
    memwb_valid = 1'(wbv); memwb_rd = W'(wbrd);
    memwb_reg_write = 1'(wbrw); memwb_mem_read = 1'(wbmr);
    @(negedge clk);
  endtask

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // Reset state: all-bubble pipeline selects the register-file values.
    check("R8", "reset a_sel", int'(fwd_a_sel), 0);
    check("R8", "reset b_sel", int'(fwd_b_sel), 0);
    check("R10", "reset store_sel", int'(fwd_store_sel), 0);
    rst_n = 1'b1;

    // Directed: same register in both stages, memory stage wins.
    drive(1, 1, 1, 1, 1, 0, 1, 0, 0, 1, 1, 1, 0);
    check("R5", "both match a_sel", int'(fwd_a_sel), 1);
    // Directed: only rt matches write-back; operands decided independently.
    drive(1, 2, 3, 1, 1, 0, 1, 0, 0, 1, 3, 1, 0);
    check("R4", "rs no match a_sel", int'(fwd_a_sel), 0);
    check("R4", "rt wb match b_sel", int'(fwd_b_sel), 2);
    // Directed: load in memory stage is not an ALU source.
    drive(1, 2, 2, 1, 2, 0, 1, 1, 0, 0, 0, 0, 0);
    check("R2", "load in mem a_sel", int'(fwd_a_sel), 0);
    // Directed: register zero never forwards.
    drive(1, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 1, 0);
    check("R6", "zero dest b_sel", int'(fwd_b_sel), 0);
    // Directed: bubble with stray write flag.
    drive(1, 1, 1, 0, 1, 0, 1, 0, 0, 0, 1, 1, 0);
    check("R7", "bubble src a_sel", int'(fwd_a_sel), 0);
    // Directed: load then store with same register.
    drive(0, 0, 0, 1, 0, 3, 0, 0, 1, 1, 3, 1, 1);
    check("R9", "load->store store_sel", int'(fwd_store_sel), 1);
    // Directed: ALU op in write-back matching store register does not fire it.
    drive(0, 0, 0, 1, 0, 3, 0, 0, 1, 1, 3, 1, 0);
    check("R10", "non-load store_sel", int'(fwd_store_sel), 0);

    // Exhaustive ALU-operand sweep.
    for (int v = 0; v < 32768; v++) begin
      int idv, rs, rt, exv, exrd, exrw, exmr, wbv, wbrd, wbrw, wbmr, ea, eb;
      idv  = v & 1;          rs   = (v >> 1) & 3;  rt   = (v >> 3) & 3;
      exv  = (v >> 5) & 1;   exrd = (v >> 6) & 3;  exrw = (v >> 8) & 1;
      exmr = (v >> 9) & 1;   wbv  = (v >> 10) & 1; wbrd = (v >> 11) & 3;
      wbrw = (v >> 13) & 1;  wbmr = (v >> 14) & 1;
      drive(idv, rs, rt, exv, exrd, 0, exrw, exmr, 0, wbv, wbrd, wbrw, wbmr);
      ea = exp_op(rs, idv, exv, exrd, exrw, exmr, wbv, wbrd, wbrw, wbmr);
      eb = exp_op(rt, idv, exv, exrd, exrw, exmr, wbv, wbrd, wbrw, wbmr);
      check(op_tag(idv, exv, exrd, exmr, wbv, wbrd, wbmr, ea), "sweep a_sel", int'(fwd_a_sel), ea);
      check(op_tag(idv, exv, exrd, exmr, wbv, wbrd, wbmr, eb), "sweep b_sel", int'(fwd_b_sel), eb);
      check("R1", "sweep code 11 absent",
            int'(fwd_a_sel == 2'b11 || fwd_b_sel == 2'b11), 0);
      check("R10", "sweep no store", int'(fwd_store_sel), 0);
    end

    // Exhaustive load-to-store sweep.
    for (int v = 0; v < 512; v++) begin
      int exv, exmw, exrt, wbv, wbrd, wbrw, wbmr, es;
      exv  = v & 1;         exmw = (v >> 1) & 1;  exrt = (v >> 2) & 3;
      wbv  = (v >> 4) & 1;  wbrd = (v >> 5) & 3;  wbrw = (v >> 7) & 1;
      wbmr = (v >> 8) & 1;
      drive(0, 0, 0, exv, 0, exrt, 0, 0, exmw, wbv, wbrd, wbrw, wbmr);
      es = exp_st(exv, exmw, exrt, wbv, wbrd, wbrw, wbmr);
      check(es == 1 ? "R9" : (wbrd == 0 ? "R6" : "R10"), "sweep store_sel",
            int'(fwd_store_sel), es);
    end

    finished = 1;
    report();
  end
endmodule